// File: doc/BRIEF.md
# Transmit Gearbox Sequence Counter Controller

This block produces the sequence count that a synchronous 64B/66B or 64B/67B transmit gearbox expects from the logic in front of it. It also produces a stall flag that tells the data source to keep its current word and header for one more count step. The count range, the rate at which the count moves and the counts at which the source must pause all depend on three settings: the line code, the internal datapath width, and whether the user interface is as wide as the internal path or twice as wide.

After reset the count sits at zero, and the source presents its first header and data. The count stays at zero until a start request is seen. From then on it advances on every user clock, or on every second user clock when the user width equals the internal width, and it wraps at the end of its range. A small header stage registers the header word and zeroes the bits that the selected line code and interface width leave unused. The settings are captured only while reset is held.

Top module: `gbx_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `seq` is 0, `stall` is 0 and `hdr_out` is 0. A start request made while `rst` is high is not remembered.
- R2: Until `start` is sampled high after reset, `seq` stays at 0 and `stall` stays low, for any number of cycles.
- R3: The clock edge that samples `start` high leaves `seq` at 0. From the next edge on, `seq` either stays where it is or moves to the previous value plus one, or to 0 after the last value. Later start requests have no effect.
- R4: With `code_sel`=0 (64B/66B) the count runs 0,1,...,32 and then returns to 0, and `seq[6]` is always 0.
- R5: With `code_sel`=1 (64B/67B) the count runs 0,1,...,66 and then returns to 0.
- R6: With `wide_sel`=0 (user width equal to internal width) the count moves on every second clock edge, starting with the second edge after the start edge, so each value lasts exactly two cycles.
- R7: With `wide_sel`=1 (user width twice the internal width) the count moves on every clock edge after the start edge.
- R8: In 64B/66B mode `stall` is high at count 31 when `intw_sel`=0 (2-byte path) and at count 32 when `intw_sel` is 1 (4-byte) or 2 (8-byte).
- R9: In 64B/67B mode `stall` is high at counts 21, 44 and 65 for the 2-byte path and at counts 22, 44 and 66 for the 4-byte and 8-byte paths.
- R10: `stall` is high on exactly those cycles where `seq` holds a pause value, which in divide-by-two modes means both cycles of that count, and it is low on all other cycles.
- R11: `hdr_out` is `hdr_in` registered one cycle. Bits [1:0] (lower lane) and [4:3] (upper lane) pass in 64B/66B mode, and bits [2:0] and [5:3] pass in 64B/67B mode. All other bits are 0. The upper lane, which is serialized first with data [127:64], passes only for a 16-byte interface (`intw_sel`=2 with `wide_sel`=1).
- R12: Changes on `code_sel`, `intw_sel` or `wide_sel` while `rst` is low have no effect on `seq`, `stall` or `hdr_out`. The values present during reset apply.
- R13: An `intw_sel` value of 3 behaves as the 8-byte path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset; also captures the settings |
| start | input | 1 | Request to begin counting |
| code_sel | input | 1 | Line code: 0 = 64B/66B, 1 = 64B/67B |
| intw_sel | input | 2 | Internal path: 0 = 2-byte, 1 = 4-byte, 2 or 3 = 8-byte |
| wide_sel | input | 1 | 1 = user width twice the internal width, 0 = equal |
| hdr_in | input | 6 | Header from the data source, two 3-bit lanes |
| seq | output | 7 | Sequence count for the gearbox |
| stall | output | 1 | Data source must hold its word and header |
| hdr_out | output | 6 | Registered header with unused bits zeroed |

## Verification
The bench runs all twelve combinations of line code, internal width and width ratio for more than one full wrap. In every cycle it compares the count, the stall flag and the masked header with a cycle model built from the requirements. A design that paused one count off for the 2-byte path, wrapped at 33 or 67, or counted the first divide phase from the start edge would differ from the model within one period. Separate scenarios hold the block idle for a long time, raise start during reset, and change every select in the middle of a run. These catch designs that start on their own, remember a start made during reset, or read the selects live instead of latching them. A stall that covered only one of the two cycles of a paused count is also caught.

// File: rtl/gbx_seq_pkg.sv
package gbx_seq_pkg;

  localparam int SEQ_W      = 7;
  localparam int LAST_66    = 32;
  localparam int LAST_67    = 66;
  localparam int P66_NARROW = 31;
  localparam int P66_WIDE   = 32;
  localparam int P67_A_NAR  = 21;
  localparam int P67_A_WID  = 22;
  localparam int P67_MID    = 44;
  localparam int P67_C_NAR  = 65;
  localparam int P67_C_WID  = 66;

  typedef enum logic {
    CODE_66 = 1'b0,
    CODE_67 = 1'b1
  } code_e;

  typedef enum logic [1:0] {
    INT_2B = 2'd0,
    INT_4B = 2'd1,
    INT_8B = 2'd2
  } intw_e;

  typedef struct packed {
    code_e code;
    intw_e intw;
    logic  wide;
  } cfg_t;

  function automatic logic [SEQ_W-1:0] last_count(input code_e c);
    if (c == CODE_67) return SEQ_W'(LAST_67);
    return SEQ_W'(LAST_66);
  endfunction

  function automatic logic is_pause(input cfg_t c, input logic [SEQ_W-1:0] v);
    logic nar;
    logic hit;
    nar = (c.intw == INT_2B);
    if (c.code == CODE_66) begin
      hit = (v == SEQ_W'(nar ? P66_NARROW : P66_WIDE));
    end else begin
      hit = (v == SEQ_W'(nar ? P67_A_NAR : P67_A_WID)) ||
            (v == SEQ_W'(P67_MID)) ||
            (v == SEQ_W'(nar ? P67_C_NAR : P67_C_WID));
    end
    return hit;
  endfunction

endpackage

// File: rtl/gbx_cfg_latch.sv
module gbx_cfg_latch
  import gbx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       code_sel,
  input  logic [1:0] intw_sel,
  input  logic       wide_sel,
  output cfg_t       cfg_q
);

  intw_e intw_dec;

  always_comb begin
    unique case (intw_sel)
      2'd0:    intw_dec = INT_2B;
      2'd1:    intw_dec = INT_4B;
      default: intw_dec = INT_8B;
    endcase
  end

  // settings are sampled only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.code <= code_sel ? CODE_67 : CODE_66;
      cfg_q.intw <= intw_dec;
      cfg_q.wide <= wide_sel;
    end
  end

endmodule

// File: rtl/gbx_seq_count.sv
module gbx_seq_count
  import gbx_seq_pkg::*;
#(
  parameter int CNT_W = SEQ_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] seq_q,
  output logic [CNT_W-1:0] seq_nxt,
  output logic             run_q
);

  logic             phase_q;
  logic             phase_nxt;
  logic             run_nxt;
  logic             adv;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] raw_nxt;

  assign last    = CNT_W'(last_count(cfg.code));
  assign adv     = run_q && (cfg.wide || phase_q);
  assign run_nxt = run_q || start;

  always_comb begin
    raw_nxt   = seq_q;
    phase_nxt = 1'b0;
    if (run_q) phase_nxt = ~phase_q;
    if (adv) begin
      if (seq_q == last) raw_nxt = '0;
      else               raw_nxt = seq_q + CNT_W'(1);
    end
  end

  // top bit only carries count in the 67 code
  always_comb begin
    seq_nxt = raw_nxt;
    if (cfg.code == CODE_66) seq_nxt[CNT_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      seq_q   <= seq_nxt;
      phase_q <= phase_nxt;
      run_q   <= run_nxt;
    end
  end

endmodule

// File: rtl/gbx_pause_flag.sv
module gbx_pause_flag
  import gbx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic [SEQ_W-1:0] seq_nxt,
  output logic             stall_q
);

  // registered from the next count so it lines up with seq
  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= is_pause(cfg, seq_nxt);
  end

endmodule

// File: rtl/gbx_hdr_mask.sv
module gbx_hdr_mask
  import gbx_seq_pkg::*;
#(
  parameter int HDR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_q
);

  localparam int LANES  = 2;
  localparam int LANE_W = HDR_W / LANES;

  logic [HDR_W-1:0] keep;
  logic [LANES-1:0] lane_on;

  assign lane_on[0] = 1'b1;
  assign lane_on[1] = (cfg.intw == INT_8B) && cfg.wide;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      if (b < 2) begin : g_base
        assign keep[l*LANE_W+b] = lane_on[l];
      end else if (b == 2) begin : g_ext
        assign keep[l*LANE_W+b] = lane_on[l] && (cfg.code == CODE_67);
      end else begin : g_none
        assign keep[l*LANE_W+b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hdr_q <= '0;
    else     hdr_q <= hdr_in & keep;
  end

endmodule

// File: rtl/gbx_seq_ctrl.sv
module gbx_seq_ctrl
  import gbx_seq_pkg::*;
#(
  parameter int HDR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             code_sel,
  input  logic [1:0]       intw_sel,
  input  logic             wide_sel,
  input  logic [HDR_W-1:0] hdr_in,
  output logic [SEQ_W-1:0] seq,
  output logic             stall,
  output logic [HDR_W-1:0] hdr_out
);

  cfg_t             cfg_q;
  logic [SEQ_W-1:0] seq_nxt;
  logic             run_q;

  gbx_cfg_latch u_cfg (
    .clk      (clk),
    .rst      (rst),
    .code_sel (code_sel),
    .intw_sel (intw_sel),
    .wide_sel (wide_sel),
    .cfg_q    (cfg_q)
  );

  gbx_seq_count #(.CNT_W(SEQ_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cfg     (cfg_q),
    .seq_q   (seq),
    .seq_nxt (seq_nxt),
    .run_q   (run_q)
  );

  gbx_pause_flag u_pause (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg_q),
    .seq_nxt (seq_nxt),
    .stall_q (stall)
  );

  gbx_hdr_mask #(.HDR_W(HDR_W)) u_hdr (
    .clk    (clk),
    .rst    (rst),
    .cfg    (cfg_q),
    .hdr_in (hdr_in),
    .hdr_q  (hdr_out)
  );

endmodule

// File: rtl/gbx_seq_ctrl_chk.sv
module gbx_seq_ctrl_chk
  import gbx_seq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input cfg_t             cfg,
  input logic             run,
  input logic [SEQ_W-1:0] seq,
  input logic             stall
);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (seq == '0 && !stall));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |-> (seq == '0 && !stall));

  a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(seq) |-> (seq == '0 || seq == $past(seq) + SEQ_W'(1)));

  a_r4_range_66: assert property (@(posedge clk) disable iff (rst)
    (cfg.code == CODE_66) |-> (seq <= SEQ_W'(LAST_66) && !seq[SEQ_W-1]));

  a_r5_range_67: assert property (@(posedge clk) disable iff (rst)
    (cfg.code == CODE_67) |-> (seq <= SEQ_W'(LAST_67)));

  a_r6_div2_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg.wide && !$stable(seq)) |=> $stable(seq));

  a_r7_div1_move: assert property (@(posedge clk) disable iff (rst)
    (cfg.wide && run && $past(run)) |-> !$stable(seq));

  a_r10_stall_at_pause: assert property (@(posedge clk) disable iff (rst)
    stall == is_pause(cfg, seq));

endmodule

bind gbx_seq_ctrl gbx_seq_ctrl_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .cfg   (cfg_q),
  .run   (run_q),
  .seq   (seq),
  .stall (stall)
);

// File: tb/tb_gbx_seq_ctrl.sv
module tb_gbx_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       code_sel = 1'b0;
  logic [1:0] intw_sel = 2'd0;
  logic       wide_sel = 1'b0;
  logic [5:0] hdr_in = 6'h00;
  logic [6:0] seq;
  logic       stall;
  logic [5:0] hdr_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state
  int   m_seq = 0;
  bit   m_run = 0, m_ph = 0;
  bit   m_code = 0, m_wide = 0;
  int   m_intw = 0;
  logic [5:0] m_hdr = 6'h00;

  always #2 clk = ~clk;

  gbx_seq_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .code_sel(code_sel),
    .intw_sel(intw_sel), .wide_sel(wide_sel), .hdr_in(hdr_in),
    .seq(seq), .stall(stall), .hdr_out(hdr_out)
  );

  function automatic bit ref_pause(bit c67, int iw, int v);
    bit nar = (iw == 0);
    if (!c67) return v == (nar ? 31 : 32);
    return v == (nar ? 21 : 22) || v == 44 || v == (nar ? 65 : 66);
  endfunction

  function automatic logic [5:0] ref_mask(bit c67, int iw, bit wd, logic [5:0] h);
    logic [2:0] lane = c67 ? 3'b111 : 3'b011;
    logic [2:0] up   = (iw >= 2 && wd) ? lane : 3'b000;
    return h & {up, lane};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: advance model from pre-edge inputs, then compare
  task automatic tick(string req);
    @(posedge clk);
    if (rst) begin
      m_code = code_sel; m_intw = intw_sel; m_wide = wide_sel;
      m_seq = 0; m_run = 0; m_ph = 0; m_hdr = 6'h00;
    end else begin
      m_hdr = ref_mask(m_code, m_intw, m_wide, hdr_in);
      if (!m_run) m_run = start;
      else begin
        if (m_wide || m_ph) m_seq = (m_seq == (m_code ? 66 : 32)) ? 0 : m_seq + 1;
        m_ph = !m_ph;
      end
    end
    #1;
    chk(seq == 7'(m_seq), {req, " seq"}, seq, m_seq);
    chk(stall == (m_run && ref_pause(m_code, m_intw, m_seq)), {req, " stall"},
        stall, m_run && ref_pause(m_code, m_intw, m_seq));
    chk(hdr_out == m_hdr, {req, " hdr (R11)"}, hdr_out, m_hdr);
  endtask

  task automatic do_reset(bit c, int iw, bit w);
    code_sel = c; intw_sel = 2'(iw); wide_sel = w; rst = 1'b1;
    repeat (3) tick("R1 reset");
    rst = 1'b0;
    tick("R1 after release");
  endtask

  // full run of one configuration past a wrap
  task automatic run_mode(bit c, int iw, bit w);
    int len = ((c ? 67 : 33) * (w ? 1 : 2)) + 12;
    do_reset(c, iw, w);
    repeat (5) tick("R2 idle");
    start = 1'b1;
    tick("R3 start edge");
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      hdr_in = 6'(i * 13 + 7);
      if (i == 40) start = 1'b1;   // later start has no effect
      if (i == 41) start = 1'b0;
      tick(c ? (w ? "R5 R7 R9" : "R5 R6 R9 R10") : (w ? "R4 R7 R8" : "R4 R6 R8 R10"));
    end
  endtask

  task automatic test_idle_and_reset_start;
    code_sel = 1'b0; intw_sel = 2'd1; wide_sel = 1'b1;
    rst = 1'b1; start = 1'b1;
    repeat (2) tick("R1 start in reset");
    start = 1'b0; rst = 1'b0;
    for (int i = 0; i < 60; i++) tick("R2 long idle");
  endtask

  task automatic test_select_change;
    do_reset(1'b0, 1, 1'b0);
    start = 1'b1; tick("R12 start"); start = 1'b0;
    repeat (20) tick("R12 before change");
    code_sel = 1'b1; intw_sel = 2'd0; wide_sel = 1'b1;
    for (int i = 0; i < 80; i++) begin
      hdr_in = 6'h3F;
      tick("R12 after change");
    end
  endtask

  task automatic test_hdr_patterns;
    do_reset(1'b1, 3, 1'b1);   // R13: value 3 acts as 8-byte
    hdr_in = 6'h3F; tick("R13 R11 all ones");
    hdr_in = 6'h2A; tick("R13 R11 pattern");
    chk(hdr_out == 6'h2A, "R13 upper lane", hdr_out, 6'h2A);
    do_reset(1'b0, 2, 1'b1);
    hdr_in = 6'h3F; tick("R11 66 wide");
    chk(hdr_out == 6'h1B, "R11 66 16-byte mask", hdr_out, 6'h1B);
    do_reset(1'b1, 2, 1'b0);
    hdr_in = 6'h3F; tick("R11 67 narrow");
    chk(hdr_out == 6'h07, "R11 67 8-byte mask", hdr_out, 6'h07);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    test_idle_and_reset_start();
    for (int c = 0; c < 2; c++)
      for (int iw = 0; iw < 3; iw++)
        for (int w = 0; w < 2; w++)
          run_mode(1'(c), iw, 1'(w));
    test_select_change();
    test_hdr_patterns();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule